// File: doc/BRIEF.md
# Bus-Master DMA Register Port

This block is the byte-addressed register window that a host uses to program a two-channel disk controller's bus-master DMA engine. Each channel owns an 8-byte slot. The low half of the slot holds a command byte and a status byte. The high half holds a 32-bit descriptor-table pointer. The block decodes host reads and writes and applies the status-register write rules. It hands the command byte, a start bit and the descriptor pointer to the DMA engine. The engine's running state and its error and interrupt events come back in as per-channel inputs.

The status byte mixes three kinds of bits:

- **Bit 0 (running):** owned by hardware and read-only.
- **Bits 1 (error) and 2 (interrupt):** event bits. Hardware sets them, and the host clears them by writing one.
- **Bits 5 and 6:** plain read/write bits.

The command/status half of a slot accepts only byte accesses. The pointer half accepts byte, halfword and word accesses.

A host access takes one cycle. A write takes effect at the clock edge. Read data is combinational on `rdata` while a read is presented.

Top module: `bmdma_regport`

## Requirements
- R1: After reset every command byte is 0x00, every start output is 0, every descriptor pointer is 0, and a status read shows only the running input in bit 0.
- R2: A byte read with address bits [1:0] = 0 returns the command byte. Bits [1:0] = 2 returns the status byte. Bits [1:0] = 1 or 3 return 0xFF. All of these apply with address bit 2 = 0.
- R3: In the command/status half (address bit 2 = 0), a read with `req_size` 1 (2 bytes) or 2 (4 bytes) returns all ones across 16 or 32 bits. A write with those sizes changes nothing.
- R4: A byte write to status loads bits 5 and 6 from the written data. Bits 3, 4 and 7 read as zero, and bit 0 always reads as the channel's running input.
- R5: A status byte write with data bit 1 or bit 2 set clears that status bit. A zero in either position leaves the bit unchanged.
- R6: A one-cycle pulse on `err_evt` or `irq_evt` sets status bit 1 or bit 2 respectively. A set event wins over a clear by the host in the same cycle.
- R7: A byte write at offset 0 loads the command byte. `cmd_byte` shows it after the write edge, and `start` equals its bit 0.
- R8: Address bit 3 selects the channel: 0 to 7 is channel 0 and 8 to 15 is channel 1. An access to one channel never alters the other.
- R9: The descriptor pointer sits at slot offsets 4 to 7 (address bit 2 = 1) and is written per byte lane. Data lane 0 goes to the addressed byte, and lanes beyond offset 7 are dropped. Reads return the pointer shifted down by the offset and masked to the size. Pointer bits [1:0] are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address within the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, lowest byte at the addressed byte |
| rdata | output | 32 | Read data, zero when no read is presented |
| dma_active | input | 2 | Per-channel engine running state |
| err_evt | input | 2 | Per-channel error event pulse |
| irq_evt | input | 2 | Per-channel interrupt event pulse |
| cmd_byte | output | 16 | Command bytes, channel 0 in bits [7:0] |
| start | output | 2 | Per-channel start bit (command bit 0) |
| desc_addr | output | 64 | Descriptor pointers, channel 0 in bits [31:0] |

## Verification
Every address is read at every size at several points: after reset, after command and status writes, and after pointer writes of mixed widths and offsets. These sweeps separate the all-ones answer to wide accesses from the byte decode, and they show the pointer's lane alignment. Status is exercised with writes of all ones and with mixed one and zero patterns. One pattern clears one event bit while the other holds, which tells a true write-one-to-clear apart from a plain write. An event and a host clear are applied in the same cycle to check the priority. Channel 1 holds different values throughout, so any leak between slots shows up in the sweeps.

// File: rtl/bmdma_regport.sv
module bmdma_regport #(
  parameter  int NCH = 2,
  localparam int CW  = $clog2(NCH),
  localparam int AW  = CW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  input  logic [NCH-1:0]    dma_active,
  input  logic [NCH-1:0]    err_evt,
  input  logic [NCH-1:0]    irq_evt,
  output logic [NCH*8-1:0]  cmd_byte,
  output logic [NCH-1:0]    start,
  output logic [NCH*32-1:0] desc_addr
);

  logic [NCH-1:0][7:0]  cmd_q;
  logic [NCH-1:0][3:0]  st_q;   // {b6, b5, b2 irq, b1 err}
  logic [NCH-1:0][31:0] adr_q;

  logic [CW-1:0] ch;
  logic [1:0]    off;
  logic          is_adr, byte_acc, wr, rd;
  logic [3:0]    lanes_n, lane_en;
  logic [31:0]   wsh, ones;
  logic [NCH-1:0] hit, cmd_we, st_we;

  assign ch       = req_addr[AW-1:3];
  assign off      = req_addr[1:0];
  assign is_adr   = req_addr[2];
  assign byte_acc = (req_size == 2'd0);
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign lanes_n  = (req_size == 2'd0) ? 4'b0001 : (req_size == 2'd1) ? 4'b0011 : 4'b1111;
  assign lane_en  = lanes_n << off;
  assign wsh      = req_wdata << (8 * off);
  assign ones     = {{8{lanes_n[3]}}, {8{lanes_n[2]}}, {8{lanes_n[1]}}, 8'hFF};

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      hit[c]    = wr && (ch == CW'(c));
      cmd_we[c] = hit[c] && !is_adr && byte_acc && (off == 2'd0);
      st_we[c]  = hit[c] && !is_adr && byte_acc && (off == 2'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      st_q  <= '0;
      adr_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cmd_we[c]) cmd_q[c] <= req_wdata[7:0];
        if (st_we[c])  st_q[c][3:2] <= req_wdata[6:5];
        st_q[c][0] <= err_evt[c] | (st_q[c][0] & ~(st_we[c] & req_wdata[1]));
        st_q[c][1] <= irq_evt[c] | (st_q[c][1] & ~(st_we[c] & req_wdata[2]));
        if (hit[c] && is_adr) begin
          for (int k = 0; k < 4; k++) begin
            if (lane_en[k]) begin
              if (k == 0) adr_q[c][7:0] <= {wsh[7:2], 2'b00};
              else        adr_q[c][k*8 +: 8] <= wsh[k*8 +: 8];
            end
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch == CW'(c)) begin
          if (is_adr)         rdata = (adr_q[c] >> (8 * off)) & ones;
          else if (!byte_acc) rdata = ones;
          else begin
            case (off)
              2'd0:    rdata = {24'd0, cmd_q[c]};
              2'd2:    rdata = {24'd0, 1'b0, st_q[c][3:2], 2'b00, st_q[c][1:0], dma_active[c]};
              default: rdata = 32'h0000_00FF;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cmd_byte[c*8 +: 8]   = cmd_q[c];
      start[c]             = cmd_q[c][0];
      desc_addr[c*32 +: 32] = adr_q[c];
    end
  end

endmodule

module bmdma_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [3:0]  req_addr,
  input logic [1:0]  req_size,
  input logic [31:0] req_wdata,
  input logic [31:0] rdata,
  input logic [1:0]  dma_active,
  input logic [1:0]  err_evt,
  input logic [1:0]  irq_evt,
  input logic [15:0] cmd_byte,
  input logic [1:0]  start,
  input logic [63:0] desc_addr
);
  logic st_wr0, rd_b;
  assign st_wr0 = req_valid && req_write && req_size == 2'd0 && req_addr == 4'd2;
  assign rd_b   = req_valid && !req_write && req_size == 2'd0;

  p_odd_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b && req_addr == 4'd1 |-> rdata == 32'h0000_00FF);

  p_wide_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size != 2'd0 && req_addr[3:2] == 2'b00 |=> $stable(cmd_byte[7:0]));

  p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b && req_addr == 4'd2 |-> rdata[7] == 1'b0 && rdata[4:3] == 2'b00 && rdata[0] == dma_active[0]);

  p_w1c_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr0 && req_wdata[1] && !err_evt[0] ##1 rd_b && req_addr == 4'd2 |-> rdata[1] == 1'b0);

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt[1] ##1 rd_b && req_addr == 4'd10 |-> rdata[2] == 1'b1);

  p_cmd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 2'd0 && req_addr == 4'd0 |=> start[0] == $past(req_wdata[0]));

  p_desc_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 2'd0 && req_addr == 4'd5 |=> desc_addr[15:8] == $past(req_wdata[7:0]));

  p_other_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr[3] == 1'b0 |=> $stable(cmd_byte[15:8]) && $stable(desc_addr[63:32]));
endmodule

bind bmdma_regport bmdma_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .rdata(rdata),
  .dma_active(dma_active), .err_evt(err_evt), .irq_evt(irq_evt),
  .cmd_byte(cmd_byte), .start(start), .desc_addr(desc_addr)
);

// File: tb/bmdma_regport_tb.sv
module bmdma_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  dma_active = '0, err_evt = '0, irq_evt = '0;
  logic [15:0] cmd_byte;
  logic [1:0]  start;
  logic [63:0] desc_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_adr [2];

  always #5 clk = ~clk;

  bmdma_regport dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .rdata(rdata),
    .dma_active(dma_active), .err_evt(err_evt), .irq_evt(irq_evt),
    .cmd_byte(cmd_byte), .start(start), .desc_addr(desc_addr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [1:0] sz);
    int c = a[3];
    int o = a[1:0];
    logic [31:0] ones = (nbytes(sz) == 4) ? 32'hFFFF_FFFF : (32'd1 << (8 * nbytes(sz))) - 32'd1;
    if (a[2]) return (m_adr[c] >> (8 * o)) & ones;
    if (sz != 2'd0) return ones;
    if (o == 0) return {24'd0, m_cmd[c]};
    if (o == 2) return {24'd0, m_st[c] | {7'd0, dma_active[c]}};
    return 32'h0000_00FF;
  endfunction

  function automatic string tag_of(logic [3:0] a, logic [1:0] sz);
    if (a[2]) return "R9";
    if (sz != 2'd0) return "R3";
    if (a[1:0] == 2'd2) return "R4";
    return "R2";
  endfunction

  task automatic model_write(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
    int c = a[3];
    int o = a[1:0];
    if (a[2]) begin
      for (int k = 0; k < 4; k++) begin
        int idx = k - o;
        if (idx >= 0 && idx < nbytes(sz)) m_adr[c][k*8 +: 8] = d[idx*8 +: 8];
      end
      m_adr[c][1:0] = 2'b00;
    end else if (sz == 2'd0) begin
      if (o == 0) m_cmd[c] = d[7:0];
      if (o == 2) m_st[c] = (d[7:0] & 8'h60) | (m_st[c] & ~d[7:0] & 8'h06);
    end
  endtask

  task automatic cycle(bit v, logic [3:0] a, logic [1:0] sz, logic [31:0] d,
                       logic [1:0] ee, logic [1:0] ie);
    @(negedge clk);
    req_valid = v; req_write = v; req_addr = a; req_size = sz; req_wdata = d;
    err_evt = ee; irq_evt = ie;
    if (v) model_write(a, sz, d);
    for (int c = 0; c < 2; c++) begin
      if (ee[c]) m_st[c][1] = 1'b1;
      if (ie[c]) m_st[c][2] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; err_evt = '0; irq_evt = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
    cycle(1'b1, a, sz, d, 2'b00, 2'b00);
  endtask

  task automatic rd_chk(logic [3:0] a, logic [1:0] sz, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    #1;
    chk(tag, rdata, exp_read(a, sz));
    req_valid = 1'b0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 3; s++)
        rd_chk(4'(a), 2'(s), tag_of(4'(a), 2'(s)));
  endtask

  task automatic outs_chk(string tag);
    @(negedge clk);
    chk({tag, " cmd_byte"}, {16'd0, cmd_byte}, {16'd0, m_cmd[1], m_cmd[0]});
    chk({tag, " start"}, {30'd0, start}, {30'd0, m_cmd[1][0], m_cmd[0][0]});
    chk({tag, " desc0"}, desc_addr[31:0], m_adr[0]);
    chk({tag, " desc1"}, desc_addr[63:32], m_adr[1]);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_cmd[c] = '0; m_st[c] = '0; m_adr[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    outs_chk("R1 reset");
    rd_chk(4'd2, 2'd0, "R1 status");
    sweep();

    // R7 R8: command bytes on both channels
    wr(4'd0, 2'd0, 32'h05);
    wr(4'd8, 2'd0, 32'hA2);
    outs_chk("R7 R8 cmd");
    // R3: wide writes to the command/status half are dropped
    wr(4'd0, 2'd1, 32'hFFFF_FFFF);
    wr(4'd8, 2'd2, 32'hFFFF_FFFF);
    wr(4'd2, 2'd2, 32'hFFFF_FFFF);
    outs_chk("R3 wide write");
    rd_chk(4'd2, 2'd0, "R3 status untouched");

    // R4: status write of all ones, running input shown
    dma_active = 2'b01;
    wr(4'd2, 2'd0, 32'hFF);
    rd_chk(4'd2, 2'd0, "R4 status ch0");
    rd_chk(4'd10, 2'd0, "R8 status ch1");

    // R6: events
    cycle(1'b0, 4'd0, 2'd0, 32'd0, 2'b01, 2'b11);
    rd_chk(4'd2, 2'd0, "R6 events ch0");
    rd_chk(4'd10, 2'd0, "R6 events ch1");
    // R5: clear error only, zero leaves interrupt bit
    wr(4'd2, 2'd0, 32'h62);
    rd_chk(4'd2, 2'd0, "R5 w1c err");
    wr(4'd10, 2'd0, 32'h04);
    rd_chk(4'd10, 2'd0, "R5 w1c irq");
    // R6: set beats clear in the same cycle
    cycle(1'b1, 4'd2, 2'd0, 32'h06, 2'b01, 2'b01);
    rd_chk(4'd2, 2'd0, "R6 set wins");
    wr(4'd2, 2'd0, 32'h06);
    rd_chk(4'd2, 2'd0, "R5 clear both");
    dma_active = 2'b10;
    sweep();

    // R9: pointer writes of mixed widths
    wr(4'd4, 2'd2, 32'h1234_5677);
    wr(4'd13, 2'd0, 32'h0000_00AB);
    wr(4'd6, 2'd1, 32'h0000_BEEF);
    wr(4'd15, 2'd2, 32'hCAFE_F00D);
    wr(4'd12, 2'd0, 32'h0000_00FF);
    outs_chk("R9 desc");
    sweep();
    wr(4'd5, 2'd2, 32'h8899_AABB);
    outs_chk("R9 offset drop");
    wr(4'd8, 2'd0, 32'h00);
    outs_chk("R8 ch1 cmd clear");
    sweep();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule